// File: doc/BRIEF.md
# Packed Instruction Field Unpacker

This block takes a shader instruction that arrives as a stream of 32-bit words and splits it into one opcode field per execution unit. The first word of every instruction is a control word. Its bits 18:7 say which of twelve units carry a field, and its bits 4:0 give the total number of words, control word included. The fields of the enabled units follow in the later words in ascending unit order. They are packed back to back from bit 0 of the second word, with no padding. A field that runs past the top of a word carries on at bit 0 of the next word.

When the last declared word has been taken, the block presents the whole instruction as one wide record. The record holds the control word, a valid flag for each unit and every field at a fixed slot. It also holds an error flag. The flag is set when the declared length disagrees with the length that the enabled units imply, when the length is out of range, or when the reserved control bits are not zero. Words are always consumed according to the declared length, so the stream stays aligned after a bad instruction.

Input back-pressure: a word moves when `in_valid` and `in_ready` are both high at a rising clock edge. Output back-pressure: a record moves when `out_valid` and `out_ready` are both high. While a record is held and `out_ready` is low, `in_ready` is low. Once the record is taken, or while none is pending, `in_ready` is high.

Top module: `instr_field_unpacker`

## Requirements
- R1: The first word accepted after reset, and the first word after each completed instruction, is the control word. `out_unit_vld[k]` equals its bit 7+k for k = 0..11, and `out_ctrl` repeats it.
- R2: The field widths for units k = 0..11 are 34, 62, 41, 43, 30, 44, 31, 30, 41, 73, 64 and 64 bits. The fields of the enabled units sit back to back in ascending k, starting at bit 0 of the second word. In `out_fields`, unit k occupies a slot of its own width that starts at the sum of the widths of all units below k.
- R3: A field that crosses a word boundary takes its low bits from the top of the earlier word and its remaining upper bits from the lowest bits of the next word.
- R4: The `out_fields` slot of every unit whose enable bit is clear reads as zero.
- R5: `out_len_err` is 1 when control bits 4:0 differ from ceil(sum of enabled widths / 32) + 1.
- R6: `out_len_err` is 1 when any of control bits 31:28 is set.
- R7: `out_len_err` is 1 for a declared length of 0 or of more than 18. A length of 0 consumes only the control word. Any other length consumes exactly that many words, so the next instruction starts correctly.
- R8: `out_valid` rises in the cycle after the last word is accepted. While `out_ready` is low, the record stays stable and `in_ready` is low.
- R9: Bits after the last field in the final word have no effect on the record.
- R10: After reset `out_valid` is 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input word present |
| in_ready | output | 1 | Block accepts a word |
| in_data | input | 32 | Instruction word |
| out_valid | output | 1 | Record present |
| out_ready | input | 1 | Consumer takes the record |
| out_ctrl | output | 32 | Control word of the record |
| out_unit_vld | output | 12 | Per-unit field present flags |
| out_fields | output | 557 | All unit fields at fixed slots |
| out_len_err | output | 1 | Length, range or reserved-bit error |

## Verification
The field mapping is tried with the following patterns:
- A single field that crosses one word boundary, which separates correct boundary splicing from a word-aligned copy.
- A sparse set of units, which shows that offsets skip disabled units while fixed slots do not.
- A run of ten adjacent units spanning fifteen words, which tests offset accumulation across many crossings.
- An empty instruction.

Error cases are each followed by a clean instruction, which tells wrong word consumption apart from a wrong flag:
- An over-long declared length.
- Reserved bits set.
- A length of zero.
- A length of twenty.

Two further cases finish the set:
- Ones written after the last field, which expose any leak of trailing bits.
- A held record with the consumer stalled, which checks back-pressure.

// File: rtl/unp_pkg.sv
package unp_pkg;
  localparam int WORD_W     = 32;
  localparam int LEN_W      = 5;
  localparam int NUNITS     = 12;
  localparam int EN_LSB     = 7;
  localparam int RSV_LSB    = 28;
  localparam int RSV_W      = 4;
  localparam int MAX_LEN    = 18;
  localparam int DATA_WORDS = MAX_LEN - 1;
  localparam int POOL_W     = DATA_WORDS * WORD_W;

  function automatic int fsize(int k);
    case (k)
      0: return 34;
      1: return 62;
      2: return 41;
      3: return 43;
      4: return 30;
      5: return 44;
      6: return 31;
      7: return 30;
      8: return 41;
      9: return 73;
      10: return 64;
      11: return 64;
      default: return 0;
    endcase
  endfunction

  function automatic int fbase(int k);
    int s;
    s = 0;
    for (int j = 0; j < k; j++) s += fsize(j);
    return s;
  endfunction

  localparam int REC_W = fbase(NUNITS);
  localparam int OFF_W = $clog2(REC_W + 1);
endpackage

// File: rtl/unp_collect.sv
module unp_collect import unp_pkg::*; (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fire,
  input  logic [WORD_W-1:0] word,
  output logic [WORD_W-1:0] ctrl_now,
  output logic [POOL_W-1:0] pool_now,
  output logic              last
);
  logic [LEN_W-1:0]  cnt;
  logic [WORD_W-1:0] ctrl_q;
  logic [POOL_W-1:0] pool_q;
  logic [LEN_W-1:0]  eff_len;

  assign ctrl_now = (cnt == '0) ? word : ctrl_q;
  assign eff_len  = (ctrl_now[LEN_W-1:0] == '0) ? LEN_W'(1) : ctrl_now[LEN_W-1:0];
  assign last     = fire && (({1'b0, cnt} + 6'd1) >= {1'b0, eff_len});

  always_comb begin
    pool_now = pool_q;
    if (cnt != '0 && cnt <= LEN_W'(DATA_WORDS))
      pool_now[(int'(cnt) - 1) * WORD_W +: WORD_W] = word;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt    <= '0;
      ctrl_q <= '0;
      pool_q <= '0;
    end else if (fire) begin
      if (cnt == '0) ctrl_q <= word;
      if (last) begin
        cnt    <= '0;
        pool_q <= '0;
      end else begin
        cnt    <= cnt + LEN_W'(1);
        pool_q <= pool_now;
      end
    end
  end

  // R7
  restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    last |=> cnt == '0);

  // R7
  first_word_ctrl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && cnt == '0 && !last) |=> ctrl_q == $past(word));
endmodule

// File: rtl/unp_lencheck.sv
module unp_lencheck import unp_pkg::*; (
  input  logic [LEN_W-1:0]  len,
  input  logic [NUNITS-1:0] en,
  input  logic [RSV_W-1:0]  rsv,
  output logic [LEN_W-1:0]  calc_len,
  output logic              err
);
  logic [OFF_W-1:0] total;

  always_comb begin
    total = '0;
    for (int k = 0; k < NUNITS; k++)
      if (en[k]) total = total + OFF_W'(fsize(k));
  end

  assign calc_len = LEN_W'((int'(total) + WORD_W - 1) / WORD_W) + LEN_W'(1);
  assign err = (len != calc_len) || (rsv != '0) || (len == '0) ||
               (len > LEN_W'(MAX_LEN));
endmodule

// File: rtl/unp_extract.sv
module unp_extract import unp_pkg::*; (
  input  logic [POOL_W-1:0] pool,
  input  logic [NUNITS-1:0] en,
  output logic [REC_W-1:0]  fields
);
  logic [OFF_W-1:0] offs [NUNITS];

  always_comb begin
    logic [OFF_W-1:0] run;
    run = '0;
    for (int k = 0; k < NUNITS; k++) begin
      offs[k] = run;
      if (en[k]) run = run + OFF_W'(fsize(k));
    end
  end

  for (genvar k = 0; k < NUNITS; k++) begin : g_unit
    localparam int SZ = fsize(k);
    localparam int BS = fbase(k);
    logic [POOL_W-1:0] shifted;
    assign shifted = pool >> offs[k];
    assign fields[BS +: SZ] = en[k] ? shifted[SZ-1:0] : '0;
  end
endmodule

// File: rtl/instr_field_unpacker.sv
module instr_field_unpacker import unp_pkg::*; (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [WORD_W-1:0] in_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [WORD_W-1:0] out_ctrl,
  output logic [NUNITS-1:0] out_unit_vld,
  output logic [REC_W-1:0]  out_fields,
  output logic              out_len_err
);
  logic              fire;
  logic              last;
  logic [WORD_W-1:0] ctrl_now;
  logic [POOL_W-1:0] pool_now;
  logic [REC_W-1:0]  fields_now;
  logic [LEN_W-1:0]  calc_len;
  logic              err_now;

  assign in_ready = !out_valid || out_ready;
  assign fire     = in_valid && in_ready;

  unp_collect u_collect (
    .clk(clk), .rst_n(rst_n), .fire(fire), .word(in_data),
    .ctrl_now(ctrl_now), .pool_now(pool_now), .last(last)
  );

  unp_lencheck u_lencheck (
    .len(ctrl_now[LEN_W-1:0]),
    .en(ctrl_now[EN_LSB +: NUNITS]),
    .rsv(ctrl_now[RSV_LSB +: RSV_W]),
    .calc_len(calc_len), .err(err_now)
  );

  unp_extract u_extract (
    .pool(pool_now), .en(ctrl_now[EN_LSB +: NUNITS]), .fields(fields_now)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid    <= 1'b0;
      out_ctrl     <= '0;
      out_unit_vld <= '0;
      out_fields   <= '0;
      out_len_err  <= 1'b0;
    end else if (last) begin
      out_valid    <= 1'b1;
      out_ctrl     <= ctrl_now;
      out_unit_vld <= ctrl_now[EN_LSB +: NUNITS];
      out_fields   <= fields_now;
      out_len_err  <= err_now;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  // R8
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_fields) && $stable(out_ctrl)));

  // R8
  rise_after_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> $past(in_valid));

  // R6
  clean_record_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_len_err) |->
      (out_ctrl[RSV_LSB +: RSV_W] == '0 && out_ctrl[LEN_W-1:0] != '0 &&
       out_ctrl[LEN_W-1:0] <= LEN_W'(MAX_LEN)));

  // R5
  len_ok_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_len_err) |-> out_ctrl[LEN_W-1:0] == calc_len_q);

  logic [LEN_W-1:0] calc_len_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) calc_len_q <= '0;
    else if (last) calc_len_q <= calc_len;
  end

  for (genvar k = 0; k < NUNITS; k++) begin : g_zero
    localparam int SZ = fsize(k);
    localparam int BS = fbase(k);
    // R4
    idle_slot_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_unit_vld[k]) |-> out_fields[BS +: SZ] == '0);
  end
endmodule

// File: tb/test_instr_field_unpacker.sv
module test_instr_field_unpacker;
  localparam int RW = 557;
  int sz [12] = '{34, 62, 41, 43, 30, 44, 31, 30, 41, 73, 64, 64};

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0;
  logic          in_ready;
  logic [31:0]   in_data = '0;
  logic          out_valid;
  logic          out_ready = 1'b1;
  logic [31:0]   out_ctrl;
  logic [11:0]   out_unit_vld;
  logic [RW-1:0] out_fields;
  logic          out_len_err;

  int total = 0;
  int bad = 0;
  int seed = 3;
  logic [31:0]   words [32];
  int            nsend;
  logic [RW-1:0] exp_rec;

  always #10 clk = ~clk;

  instr_field_unpacker i_instr_field_unpacker (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .out_valid(out_valid), .out_ready(out_ready),
    .out_ctrl(out_ctrl), .out_unit_vld(out_unit_vld), .out_fields(out_fields),
    .out_len_err(out_len_err)
  );

  task automatic chk(input bit ok, input string req, input logic [RW-1:0] act,
                     input logic [RW-1:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic void build(input logic [11:0] mask, input bit len_sel,
                                input logic [4:0] len_val, input logic [3:0] rsv,
                                input bit garbage);
    int off, calc, base, pos, len;
    logic [31:0] c;
    off = 0;
    base = 0;
    exp_rec = '0;
    for (int i = 0; i < 32; i++) words[i] = '0;
    for (int k = 0; k < 12; k++) begin
      if (mask[k]) begin
        for (int b = 0; b < sz[k]; b++) begin
          logic v;
          v = (((b * 7) + (k * 13) + seed) % 5) < 2;
          pos = 32 + off + b;
          words[pos / 32][pos % 32] = v;
          exp_rec[base + b] = v;
        end
        off += sz[k];
      end
      base += sz[k];
    end
    calc = (off + 31) / 32 + 1;
    if (garbage)
      for (int p = 32 + off; p < calc * 32; p++) words[p / 32][p % 32] = 1'b1;
    len = len_sel ? int'(len_val) : calc;
    c = '0;
    c[4:0] = 5'(len);
    c[18:7] = mask;
    c[31:28] = rsv;
    words[0] = c;
    nsend = (len == 0) ? 1 : len;
    for (int i = calc; i < nsend; i++) words[i] = 32'hC0DE_0000 | 32'(i);
    seed++;
  endfunction

  task automatic push();
    for (int i = 0; i < nsend; i++) begin
      @(negedge clk);
      in_valid = 1'b1;
      in_data = words[i];
      while (!in_ready) @(negedge clk);
      @(posedge clk);
    end
  endtask

  task automatic run_case(input string tag, input logic [11:0] mask, input bit len_sel,
                          input logic [4:0] len_val, input logic [3:0] rsv,
                          input bit garbage, input bit exp_err);
    logic [31:0] c;
    build(mask, len_sel, len_val, rsv, garbage);
    c = words[0];
    push();
    @(negedge clk);
    in_valid = 1'b0;
    chk(out_valid === 1'b1, {tag, " out_valid after last word (R8)"}, RW'(out_valid), RW'(1));
    chk(out_fields === exp_rec, {tag, " fields"}, out_fields, exp_rec);
    chk(out_unit_vld === mask && out_ctrl === c, {tag, " unit flags (R1)"},
        RW'(out_unit_vld), RW'(mask));
    chk(out_len_err === exp_err, {tag, " error flag"}, RW'(out_len_err), RW'(exp_err));
    @(negedge clk);
  endtask

  task automatic t_reset();
    chk(out_valid === 1'b0, "R10 out_valid", RW'(out_valid), RW'(0));
    chk(in_ready === 1'b1, "R10 in_ready", RW'(in_ready), RW'(1));
  endtask

  task automatic t_backpressure();
    logic [RW-1:0] held;
    out_ready = 1'b0;
    build(12'h021, 1'b0, 5'd0, 4'd0, 1'b0);
    held = exp_rec;
    push();
    @(negedge clk);
    in_valid = 1'b0;
    for (int i = 0; i < 3; i++) begin
      chk(out_valid === 1'b1 && out_fields === held, "R8 record held", out_fields, held);
      chk(in_ready === 1'b0, "R8 in_ready low while held", RW'(in_ready), RW'(0));
      @(negedge clk);
    end
    out_ready = 1'b1;
    @(negedge clk);
    chk(out_valid === 1'b0, "R8 record released", RW'(out_valid), RW'(0));
    chk(in_ready === 1'b1, "R8 in_ready back", RW'(in_ready), RW'(1));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #1;
    t_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    run_case("R3 single crossing field", 12'h001, 1'b0, 5'd0, 4'd0, 1'b0, 1'b0);
    run_case("R2 R4 sparse units", 12'h225, 1'b0, 5'd0, 4'd0, 1'b0, 1'b0);
    run_case("R2 R3 ten units", 12'h3FF, 1'b0, 5'd0, 4'd0, 1'b0, 1'b0);
    run_case("R7 empty instruction", 12'h000, 1'b0, 5'd0, 4'd0, 1'b0, 1'b0);
    run_case("R5 long declared length", 12'h002, 1'b1, 5'd4, 4'd0, 1'b0, 1'b1);
    run_case("R5 next aligned", 12'h0C0, 1'b0, 5'd0, 4'd0, 1'b0, 1'b0);
    run_case("R6 reserved bits", 12'h010, 1'b0, 5'd0, 4'h4, 1'b0, 1'b1);
    run_case("R7 zero length", 12'h000, 1'b1, 5'd0, 4'd0, 1'b0, 1'b1);
    run_case("R7 after zero length", 12'h408, 1'b0, 5'd0, 4'd0, 1'b0, 1'b0);
    run_case("R7 length twenty", 12'h000, 1'b1, 5'd20, 4'd0, 1'b0, 1'b1);
    run_case("R7 after length twenty", 12'h900, 1'b0, 5'd0, 4'd0, 1'b0, 1'b0);
    run_case("R9 trailing ones", 12'h010, 1'b0, 5'd0, 4'd0, 1'b1, 1'b0);
    run_case("R9 trailing ones wide", 12'h201, 1'b0, 5'd0, 4'd0, 1'b1, 1'b0);
    t_backpressure();
    run_case("R1 after stall", 12'h180, 1'b0, 5'd0, 4'd0, 1'b0, 1'b0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule